// File: doc/BRIEF.md
# Packed-Byte Subroutine Dispatcher

This block runs the compact call mode of a vector display processor. A program enters the mode with one special instruction word. The word that follows it gives the base address of a 256-word jump table. After that comes a stream of code words, and each code word packs two byte codes. For every byte the dispatcher reads one table entry. It pushes a return address onto its own 8-deep return stack and hands the table entry to the instruction executor as the new program counter. The executor then runs that subroutine in the normal way.

The executor reports its own nested calls (`sub_call`) and returns (`sub_ret`) to the dispatcher, which keeps the one return stack for both. The dispatcher notes the stack depth just before each of its own calls. When a return brings the stack back to that depth, the dispatcher takes control again and moves on to the next byte. The byte code 0xFF ends the mode, and execution continues at the word after the current code word. All memory reads go through a simple synchronous port, and the data comes back one cycle after the request.

Top module: `byte_call_seq`

## Requirements
- R1: The mode starts only when `instr_valid` is high, `instr_word` equals 0x7F91 and the mode is inactive. Every other word is ignored: `cam_active` and `rd_en` stay low.
- R2: The first read goes to `instr_pc`+1 and returns the table base. If bits [7:0] of the base are not zero, the sticky `err_align` is set and dispatch goes on with the unaligned base.
- R3: The next read, at `instr_pc`+2, returns the first code word. Its byte [15:8] is dispatched before its byte [7:0].
- R4: The byte 0xFF ends the mode. In that cycle `pc_load` is high with `pc_value` equal to the code-word address + 1, and `cam_active` then falls.
- R5: Any other byte starts a read at base OR byte and pushes the code-word address onto the stack. In the next cycle `pc_load` is high with `pc_value` equal to the word read from the table.
- R6: A `sub_ret` resumes dispatch only when the depth after its pop equals the depth recorded before the dispatcher's push. Returns from deeper nested calls do not resume dispatch.
- R7: After resuming on the high byte, the dispatcher takes the low byte of the same word. After resuming on the low byte, it reads the code word at the next address.
- R8: An entry word that arrives while the mode is active sets the sticky `err_reentry` and does not change the running sequence.
- R9: `halt` makes the block inactive at once. Later returns do not resume dispatch and load no program counter.
- R10: The return stack holds 8 entries and is last-in, first-out, with `ret_addr` showing the top entry. A push while full or a pop while empty sets the sticky `err_stack` and leaves `depth` unchanged.
- R11: A read is one cycle with `rd_en` high and an address on `rd_addr`. The dispatcher uses `rd_data` one cycle later. `busy` is high while the dispatcher owns the sequence and low while a subroutine runs.
- R12: After reset the mode is inactive, `depth` is 0, all error flags are low, and `rd_en` and `pc_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction word is present |
| instr_word | input | 16 | The instruction word |
| instr_pc | input | 16 | Address of that instruction |
| halt | input | 1 | Processor halt |
| sub_call | input | 1 | The executor pushes `sub_ret_pc` |
| sub_ret_pc | input | 16 | Return address for an executor call |
| sub_ret | input | 1 | The executor pops (subroutine return) |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 16 | Read data, valid one cycle after the request |
| pc_load | output | 1 | The executor must load `pc_value` |
| pc_value | output | 16 | New program counter |
| ret_addr | output | 16 | Top of the return stack |
| depth | output | 4 | Number of stack entries |
| cam_active | output | 1 | Compact call mode is active |
| busy | output | 1 | The dispatcher owns the sequence |
| err_align | output | 1 | Sticky: table base not aligned |
| err_reentry | output | 1 | Sticky: entry word while active |
| err_stack | output | 1 | Sticky: stack overflow or underflow |

## Verification
The bench targets the depth match with a nested call inside a dispatched subroutine. A design that resumed on any return would fetch the next byte one call level too early and load a program counter the scoreboard does not expect. It also covers the step from the high byte to the low byte and the step to the next code word. A wrong byte order or a missing pointer increment would load the wrong table entries. A 0xFF in the high byte checks that the exit address is the code word + 1 and that the low byte is never dispatched. An unaligned base checks the OR-formed table address, and a halt in the middle of a subroutine checks that a later return loads nothing. Filling the stack to its limit and emptying it past zero checks that the error flag is set and that the depth does not wrap.

// File: rtl/byte_call_seq.sv
module byte_call_seq #(
  parameter int AW = 16,
  parameter int DEPTH = 8,
  parameter logic [15:0] ENTRY_WORD = 16'h7F91
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr_word,
  input  logic [AW-1:0] instr_pc,
  input  logic          halt,
  input  logic          sub_call,
  input  logic [AW-1:0] sub_ret_pc,
  input  logic          sub_ret,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_data,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic [AW-1:0] ret_addr,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic          cam_active,
  output logic          busy,
  output logic          err_align,
  output logic          err_reentry,
  output logic          err_stack
);
  localparam int DW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_BASE, S_WAIT_BASE, S_REQ_CODE, S_WAIT_CODE, S_DISPATCH, S_WAIT_TAB, S_RUN
  } state_t;

  state_t        state;
  logic [AW-1:0] ptr, base, code;
  logic          half;
  logic [DW-1:0] depth_q, depth_rec;
  logic [AW-1:0] stk [DEPTH];

  logic [7:0]    cur_byte;
  logic          is_exit, enter, ext_ok, seq_push;
  logic          push_req, pop_req, full, empty, do_push, do_pop, resume;
  logic [AW-1:0] push_val;
  logic [DW-1:0] top_idx;

  assign cur_byte = half ? code[7:0] : code[15:8];
  assign is_exit  = cur_byte == 8'hFF;
  assign enter    = instr_valid && instr_word == ENTRY_WORD;
  assign ext_ok   = state == S_IDLE || state == S_RUN;
  assign seq_push = !halt && state == S_DISPATCH && !is_exit;
  assign push_req = seq_push || (ext_ok && sub_call);
  assign pop_req  = ext_ok && sub_ret && !sub_call;
  assign push_val = seq_push ? ptr : sub_ret_pc;
  assign full     = depth_q == DW'(DEPTH);
  assign empty    = depth_q == '0;
  assign do_push  = push_req && !full;
  assign do_pop   = pop_req && !empty;
  assign resume   = state == S_RUN && do_pop && (depth_q - DW'(1)) == depth_rec;
  assign top_idx  = depth_q - DW'(1);

  assign rd_en    = !halt && (state == S_REQ_BASE || state == S_REQ_CODE || seq_push);
  assign rd_addr  = (state == S_DISPATCH) ? (base | {{(AW-8){1'b0}}, cur_byte}) : ptr;
  assign pc_load  = !halt && (state == S_WAIT_TAB || (state == S_DISPATCH && is_exit));
  assign pc_value = (state == S_WAIT_TAB) ? rd_data : ptr + AW'(1);
  assign ret_addr = empty ? '0 : stk[top_idx[IW-1:0]];
  assign depth    = depth_q;
  assign cam_active = state != S_IDLE;
  assign busy     = cam_active && state != S_RUN;

  always_ff @(posedge clk) begin
    if (do_push) stk[depth_q[IW-1:0]] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (do_push) begin
      depth_q <= depth_q + DW'(1);
    end else if (do_pop) begin
      depth_q <= depth_q - DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr <= '0;
      base <= '0;
      code <= '0;
      half <= 1'b0;
      depth_rec <= '0;
      err_align <= 1'b0;
      err_reentry <= 1'b0;
      err_stack <= 1'b0;
    end else begin
      if (enter && state != S_IDLE) err_reentry <= 1'b1;
      if ((push_req && full) || (pop_req && empty)) err_stack <= 1'b1;
      if (halt) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (enter) begin
            ptr <= instr_pc + AW'(1);
            state <= S_REQ_BASE;
          end
          S_REQ_BASE: state <= S_WAIT_BASE;
          S_WAIT_BASE: begin
            base <= rd_data;
            if (rd_data[7:0] != 8'h00) err_align <= 1'b1;
            ptr <= ptr + AW'(1);
            state <= S_REQ_CODE;
          end
          S_REQ_CODE: state <= S_WAIT_CODE;
          S_WAIT_CODE: begin
            code <= rd_data;
            half <= 1'b0;
            state <= S_DISPATCH;
          end
          S_DISPATCH: begin
            if (is_exit) begin
              state <= S_IDLE;
            end else begin
              depth_rec <= depth_q;
              state <= S_WAIT_TAB;
            end
          end
          S_WAIT_TAB: state <= S_RUN;
          S_RUN: if (resume) begin
            if (!half) begin
              half <= 1'b1;
              state <= S_DISPATCH;
            end else begin
              half <= 1'b0;
              ptr <= ptr + AW'(1);
              state <= S_REQ_CODE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/byte_call_seq_chk.sv
module byte_call_seq_chk #(
  parameter int AW = 16,
  parameter int DEPTH = 8,
  parameter logic [15:0] ENTRY_WORD = 16'h7F91
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [15:0]   instr_word,
  input logic          halt,
  input logic          rd_en,
  input logic          pc_load,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic          cam_active,
  input logic          err_align,
  input logic          err_reentry,
  input logic          err_stack
);
  p_reentry_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cam_active && instr_valid && instr_word == ENTRY_WORD) |=> err_reentry);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_reentry |=> err_reentry);
  p_sticky_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |=> err_align);
  p_halt_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !cam_active);
  p_load_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> cam_active);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= ($clog2(DEPTH+1))'(DEPTH));
  p_depth_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == $past(depth) || depth == $past(depth) + 1'b1 || depth == $past(depth) - 1'b1));
  p_sticky_stack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_stack |=> err_stack);
  p_idle_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cam_active |-> !rd_en);
endmodule

bind byte_call_seq byte_call_seq_chk #(.AW(AW), .DEPTH(DEPTH), .ENTRY_WORD(ENTRY_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
  .halt(halt), .rd_en(rd_en), .pc_load(pc_load), .depth(depth),
  .cam_active(cam_active), .err_align(err_align), .err_reentry(err_reentry),
  .err_stack(err_stack)
);

// File: tb/byte_call_seq_tb_top.sv
`timescale 1ns/1ps
module byte_call_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [15:0] instr_pc = '0;
  logic halt = 1'b0;
  logic sub_call = 1'b0;
  logic [15:0] sub_ret_pc = '0;
  logic sub_ret = 1'b0;
  logic rd_en;
  logic [15:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic pc_load;
  logic [15:0] pc_value;
  logic [15:0] ret_addr;
  logic [3:0] depth;
  logic cam_active, busy, err_align, err_reentry, err_stack;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] mem [4096];

  always #5 clk = ~clk;

  byte_call_seq dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_pc(instr_pc), .halt(halt), .sub_call(sub_call), .sub_ret_pc(sub_ret_pc),
    .sub_ret(sub_ret), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pc_load(pc_load), .pc_value(pc_value), .ret_addr(ret_addr), .depth(depth),
    .cam_active(cam_active), .busy(busy), .err_align(err_align),
    .err_reentry(err_reentry), .err_stack(err_stack)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[11:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pc_load) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R5/R9 unexpected pc_load actual=%0h expected=none", pc_value);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (pc_value !== e) begin
          errors++;
          $display("FAIL R5/R4 pc_value actual=%0h expected=%0h", pc_value, e);
        end
      end
    end
  end

  task automatic expect_pc(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  task automatic enter_at(input logic [15:0] w, input logic [15:0] pc);
    instr_valid = 1'b1; instr_word = w; instr_pc = pc;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic pulse_ret();
    sub_ret = 1'b1;
    @(negedge clk);
    sub_ret = 1'b0;
  endtask

  task automatic push_val(input logic [15:0] v);
    sub_call = 1'b1; sub_ret_pc = v;
    @(negedge clk);
    sub_call = 1'b0;
  endtask

  task automatic wait_load();
    int n = 0;
    while (!pc_load && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(pc_load, "R11 pc_load arrival", int'(pc_load), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[16'h041] = 16'h0200; mem[16'h042] = 16'h0305; mem[16'h043] = 16'h07FF;
    mem[16'h203] = 16'h1111; mem[16'h205] = 16'h2222; mem[16'h207] = 16'h3333;
    mem[16'h051] = 16'h0200; mem[16'h052] = 16'hFF12;
    mem[16'h071] = 16'h0210; mem[16'h072] = 16'h03FF; mem[16'h213] = 16'h4444;
    mem[16'h081] = 16'h0200; mem[16'h082] = 16'h0305;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cam_active && depth == 0 && !rd_en && !pc_load, "R12 reset state", {cam_active, depth}, 0);
    chk(!err_align && !err_reentry && !err_stack, "R12 error flags", {err_align, err_reentry, err_stack}, 0);

    // R1 R2 R3 R5 R6 R7 R4: two-word sequence with nesting
    expect_pc(16'h1111); expect_pc(16'h2222); expect_pc(16'h3333); expect_pc(16'h0044);
    enter_at(16'h7F91, 16'h0040);
    chk(rd_en && rd_addr == 16'h0041, "R2 base read address", rd_addr, 16'h0041);
    chk(busy, "R11 busy during fetch", int'(busy), 1);
    wait_load();
    @(negedge clk);
    chk(!busy && depth == 1, "R11 subroutine running", {busy, depth}, 1);
    chk(ret_addr == 16'h0042, "R5 pushed code word address", ret_addr, 16'h0042);
    pulse_ret();
    wait_load();
    @(negedge clk);
    push_val(16'h5555);
    chk(depth == 2 && ret_addr == 16'h5555, "R10 nested push", ret_addr, 16'h5555);
    pulse_ret();
    chk(cam_active && !busy && depth == 1, "R6 nested return does not resume", {busy, depth}, 1);
    pulse_ret();
    chk(rd_en && rd_addr == 16'h0043, "R7 next code word read", rd_addr, 16'h0043);
    wait_load();
    @(negedge clk);
    pulse_ret();
    wait_load();
    @(negedge clk);
    chk(!cam_active && depth == 0, "R4 exit clears mode", {cam_active, depth}, 0);
    chk(!err_align && !err_reentry, "R2 aligned base no error", err_align, 0);

    // R4: exit on high byte, low byte never dispatched
    expect_pc(16'h0053);
    enter_at(16'h7F91, 16'h0050);
    wait_load();
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!cam_active && exp_q.size() == 0, "R4 high byte exit", cam_active, 0);

    // R2 unaligned base, R8 reentry
    expect_pc(16'h4444); expect_pc(16'h0073);
    enter_at(16'h7F91, 16'h0070);
    wait_load();
    @(negedge clk);
    chk(err_align, "R2 unaligned base flag", int'(err_align), 1);
    chk(!err_reentry, "R8 no reentry yet", int'(err_reentry), 0);
    enter_at(16'h7F91, 16'h0070);
    chk(err_reentry && cam_active && !busy, "R8 reentry flagged, sequence kept", {err_reentry, busy}, 2);
    pulse_ret();
    wait_load();
    @(negedge clk);
    chk(!cam_active && exp_q.size() == 0, "R8 sequence completed", cam_active, 0);

    // R9 halt
    expect_pc(16'h1111);
    enter_at(16'h7F91, 16'h0080);
    wait_load();
    @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    chk(!cam_active, "R9 halt clears mode", int'(cam_active), 0);
    pulse_ret();
    repeat (4) @(negedge clk);
    chk(!cam_active && depth == 0 && !rd_en, "R9 no resume after halt", {cam_active, depth}, 0);

    // R1 other word ignored
    instr_valid = 1'b1; instr_word = 16'h7F92; instr_pc = 16'h0090;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(!cam_active && !rd_en, "R1 other word ignored", {cam_active, rd_en}, 0);
    repeat (3) @(negedge clk);
    chk(!cam_active && !rd_en, "R1 still inactive", {cam_active, rd_en}, 0);

    // R10 stack limits
    chk(!err_stack, "R10 no stack error yet", int'(err_stack), 0);
    for (int i = 0; i < 8; i++) push_val(16'h0A00 + 16'(i));
    chk(depth == 8 && ret_addr == 16'h0A07 && !err_stack, "R10 full stack", ret_addr, 16'h0A07);
    push_val(16'h0BBB);
    chk(err_stack && depth == 8 && ret_addr == 16'h0A07, "R10 overflow", {err_stack, depth}, 24);
    for (int i = 7; i >= 0; i--) begin
      chk(ret_addr == 16'h0A00 + 16'(i), "R10 LIFO order", ret_addr, 16'h0A00 + 16'(i));
      pulse_ret();
    end
    chk(depth == 0, "R10 emptied", depth, 0);
    pulse_ret();
    chk(depth == 0 && err_stack, "R10 underflow holds depth", depth, 0);

    chk(exp_q.size() == 0, "R5 all loads seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule